// File: doc/BRIEF.md
# Windowed Command and Status Front End

This block is the host-facing register front end of a network controller. The host writes 16-bit command words into a single command port. It reads one 16-bit status word, which is visible no matter which register window is selected. Each command word is split into a 5-bit opcode and an 11-bit argument. The opcode selects the action: it can change the register window, turn the transmitter, receiver, statistics or transceiver on or off, pulse a reset, load the interrupt mask, load the receive filter, load one of three thresholds, or raise or acknowledge interrupt events.

Hardware events arrive as one-cycle strobes from the datapath, which is outside this block. They are latched into the status word. An interrupt line is raised when the latch bit is set and at least one unmasked event is pending. The global reset, receiver reset and transmitter reset commands each start a busy period of `BUSY_CYCLES` clocks. During that period the status word shows a command in progress.

Commands enter through a valid/ready handshake. A word is taken on a rising clock edge where `cmd_valid` and `cmd_ready` are both high. While the block is busy, `cmd_ready` is low. The host must then hold the word and `cmd_valid` until ready returns, and no state changes on its account. The event strobes and all outputs are plain signals with no handshake.

Top module: `wcs_cmd_status`

## Requirements
- R1: Opcode is `cmd_word[15:11]` and argument is `cmd_word[10:0]`. A command acts only on an edge where `cmd_valid` and `cmd_ready` are both high. Opcodes 0x06, 0x07, 0x08, 0x0F, 0x14 and 0x18-0x1F change nothing.
- R2: Opcode 0x01 sets `window` to argument bits 2:0. `status_word[15:13]` always equals `window`.
- R3: Opcode 0x04 sets `rx_enable` and 0x03 clears it. Opcode 0x09 sets `tx_enable` and 0x0A clears it. Both are low after power-up reset.
- R4: Opcode 0x05 clears `rx_enable` and pulses `rx_reset_pulse` high for one cycle after the accepting edge. Opcode 0x0B does the same for `tx_enable` and `tx_reset_pulse`.
- R5: After opcode 0x00, 0x05 or 0x0B is accepted, `status_word[12]` is high and `cmd_ready` is low for exactly `BUSY_CYCLES` cycles. No command is accepted during that time.
- R6: Opcode 0x00 (global reset) does all of the following:
  - sets the window to 0;
  - clears status bits 7:0 and the mask;
  - clears the transmitter, receiver, statistics and transceiver enables, and the filter;
  - sets all three thresholds to 2047;
  - pulses both reset outputs.
  Event strobes in that same cycle are dropped. The power-up reset state is identical, except that no reset pulses occur.
- R7: Event strobes set status bits as follows: adapter failure bit 1, transmit complete bit 2, transmit available bit 3, receive complete bit 4, receive early bit 5, update statistics bit 7. Opcode 0x0C sets bit 6. Any bit set in a cycle also sets the latch, bit 0.
- R8: Opcode 0x0D clears every status bit 7:0 whose position is set in argument bits 7:0. A bit set by an event in the same cycle stays set, and so does the latch.
- R9: Opcode 0x0E loads the mask from argument bits 7:1. `irq` is high exactly when status bit 0 is set and some status bit in 7:1 is set with its mask bit set.
- R10: Opcode 0x10 loads `rx_filter` from argument bits 3:0. The bits mean: bit 0 individual address, bit 1 multicast, bit 2 broadcast, bit 3 promiscuous.
- R11: Opcodes 0x11, 0x12 and 0x13 load the receive-early, transmit-available and transmit-start thresholds from the argument. While the receive-early threshold is 2047, the receive-early strobe is ignored. While the transmit-available threshold is 2047, the transmit-available strobe is ignored.
- R12: Opcodes 0x15 and 0x16 set and clear `stats_enable`. Opcodes 0x02 and 0x17 set and clear `xcvr_on`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous power-up reset |
| cmd_valid | input | 1 | Command word offered |
| cmd_ready | output | 1 | Block can take a command (low while busy) |
| cmd_word | input | 16 | Opcode in 15:11, argument in 10:0 |
| ev_fail | input | 1 | Adapter failure strobe |
| ev_tx_done | input | 1 | Transmit complete strobe |
| ev_tx_room | input | 1 | Transmit space available strobe |
| ev_rx_done | input | 1 | Receive complete strobe |
| ev_rx_early | input | 1 | Receive early strobe |
| ev_stats | input | 1 | Statistics update strobe |
| status_word | output | 16 | Window, busy flag, event bits and latch |
| window | output | 3 | Selected register window |
| rx_enable | output | 1 | Receiver enabled |
| tx_enable | output | 1 | Transmitter enabled |
| rx_reset_pulse | output | 1 | One-cycle receiver reset |
| tx_reset_pulse | output | 1 | One-cycle transmitter reset |
| stats_enable | output | 1 | Statistics collection enabled |
| xcvr_on | output | 1 | Transceiver started |
| rx_filter | output | 4 | Receive filter bits |
| thr_rx_early | output | 11 | Receive-early threshold |
| thr_tx_room | output | 11 | Transmit-available threshold |
| thr_tx_start | output | 11 | Transmit-start threshold |
| irq | output | 1 | Interrupt request |

## Verification
The two functions that meet in one cycle are the acknowledge command and an event strobe that targets the same or a different status bit. A second such pair is a global reset accepted in the same cycle as an event strobe.

The bench drives the strobe in the same cycle that the command word is presented. It then compares the status word against a behavioural model on the next clock. In that model, a set from an event beats a clear from an acknowledge, while a global reset beats everything. A command held during a busy period is also checked, to confirm it takes effect only once ready returns.

// File: rtl/wcs_pkg.sv
package wcs_pkg;
  localparam int CMD_W = 16;
  localparam int OP_W  = 5;
  localparam int ARG_W = CMD_W - OP_W;

  typedef enum logic [OP_W-1:0] {
    OP_GLOBAL_RST = 5'h00,
    OP_WIN_SEL    = 5'h01,
    OP_XCVR_ON    = 5'h02,
    OP_RX_OFF     = 5'h03,
    OP_RX_ON      = 5'h04,
    OP_RX_RST     = 5'h05,
    OP_TX_ON      = 5'h09,
    OP_TX_OFF     = 5'h0A,
    OP_TX_RST     = 5'h0B,
    OP_INT_REQ    = 5'h0C,
    OP_INT_ACK    = 5'h0D,
    OP_MASK_LD    = 5'h0E,
    OP_FILT_LD    = 5'h10,
    OP_THR_RXE    = 5'h11,
    OP_THR_TXA    = 5'h12,
    OP_THR_TXS    = 5'h13,
    OP_STATS_ON   = 5'h15,
    OP_STATS_OFF  = 5'h16,
    OP_XCVR_OFF   = 5'h17
  } op_e;

  typedef struct packed {
    logic gl_rst;
    logic win_sel;
    logic rx_on;
    logic rx_off;
    logic rx_rst;
    logic tx_on;
    logic tx_off;
    logic tx_rst;
    logic int_req;
    logic int_ack;
    logic mask_ld;
    logic filt_ld;
    logic thr_rxe;
    logic thr_txa;
    logic thr_txs;
    logic st_on;
    logic st_off;
    logic xc_on;
    logic xc_off;
  } dec_t;
endpackage

// File: rtl/wcs_decode.sv
module wcs_decode
  import wcs_pkg::*;
(
  input  logic             fire,
  input  logic [CMD_W-1:0] word,
  output dec_t             d,
  output logic [ARG_W-1:0] arg
);
  logic [OP_W-1:0] op;
  assign op  = word[CMD_W-1:ARG_W];
  assign arg = word[ARG_W-1:0];

  always_comb begin
    d = '0;
    if (fire) begin
      case (op)
        OP_GLOBAL_RST: d.gl_rst  = 1'b1;
        OP_WIN_SEL:    d.win_sel = 1'b1;
        OP_XCVR_ON:    d.xc_on   = 1'b1;
        OP_RX_OFF:     d.rx_off  = 1'b1;
        OP_RX_ON:      d.rx_on   = 1'b1;
        OP_RX_RST:     d.rx_rst  = 1'b1;
        OP_TX_ON:      d.tx_on   = 1'b1;
        OP_TX_OFF:     d.tx_off  = 1'b1;
        OP_TX_RST:     d.tx_rst  = 1'b1;
        OP_INT_REQ:    d.int_req = 1'b1;
        OP_INT_ACK:    d.int_ack = 1'b1;
        OP_MASK_LD:    d.mask_ld = 1'b1;
        OP_FILT_LD:    d.filt_ld = 1'b1;
        OP_THR_RXE:    d.thr_rxe = 1'b1;
        OP_THR_TXA:    d.thr_txa = 1'b1;
        OP_THR_TXS:    d.thr_txs = 1'b1;
        OP_STATS_ON:   d.st_on   = 1'b1;
        OP_STATS_OFF:  d.st_off  = 1'b1;
        OP_XCVR_OFF:   d.xc_off  = 1'b1;
        default:       d = '0;
      endcase
    end
  end
endmodule

// File: rtl/wcs_busy.sv
module wcs_busy #(
  parameter int CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CNT_W = $clog2(CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(CYCLES);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt_q <= '0;
    else if (start)      cnt_q <= LOAD;
    else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != 0);

  // R5: a reset-class command always opens a busy window
  a_r5_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
endmodule

// File: rtl/wcs_irq_status.sv
module wcs_irq_status #(
  parameter int EV_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic [EV_W-1:1] set_vec,
  input  logic            ack_en,
  input  logic [EV_W-1:0] ack_vec,
  input  logic            mask_ld,
  input  logic [EV_W-1:1] mask_in,
  output logic [EV_W-1:0] ev_bits,
  output logic            irq
);
  logic [EV_W-1:1] ev_q;
  logic            latch_q;
  logic [EV_W-1:1] mask_q;
  logic [EV_W-1:0] ack_eff;

  assign ack_eff = ack_en ? ack_vec : '0;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      ev_q    <= '0;
      latch_q <= 1'b0;
      mask_q  <= '0;
    end else begin
      ev_q    <= (ev_q & ~ack_eff[EV_W-1:1]) | set_vec;
      latch_q <= (latch_q & ~ack_eff[0]) | (|set_vec);
      if (mask_ld) mask_q <= mask_in;
    end
  end

  assign ev_bits = {ev_q, latch_q};
  assign irq     = latch_q && |(ev_q & mask_q);

  // R9: the interrupt line never rises without the latch
  a_r9_irq_needs_latch: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ev_bits[0]);
  // R8: a fresh event survives a same-cycle acknowledge
  a_r8_set_beats_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec[2] && !clear) |=> (ev_bits[2] && ev_bits[0]));
endmodule

// File: rtl/wcs_cmd_status.sv
module wcs_cmd_status
  import wcs_pkg::*;
#(
  parameter int BUSY_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  output logic        cmd_ready,
  input  logic [15:0] cmd_word,
  input  logic        ev_fail,
  input  logic        ev_tx_done,
  input  logic        ev_tx_room,
  input  logic        ev_rx_done,
  input  logic        ev_rx_early,
  input  logic        ev_stats,
  output logic [15:0] status_word,
  output logic [2:0]  window,
  output logic        rx_enable,
  output logic        tx_enable,
  output logic        rx_reset_pulse,
  output logic        tx_reset_pulse,
  output logic        stats_enable,
  output logic        xcvr_on,
  output logic [3:0]  rx_filter,
  output logic [10:0] thr_rx_early,
  output logic [10:0] thr_tx_room,
  output logic [10:0] thr_tx_start,
  output logic        irq
);
  localparam int WIN_W  = 3;
  localparam int FILT_W = 4;
  localparam int EV_W   = 8;
  localparam int THR_W  = ARG_W;
  localparam logic [THR_W-1:0] THR_OFF = '1;

  logic             busy, fire;
  dec_t             d;
  logic [ARG_W-1:0] arg;
  logic [EV_W-1:1]  set_vec;
  logic [EV_W-1:0]  ev_bits;
  logic [WIN_W-1:0] win_q;
  logic             rx_en_q, tx_en_q, st_q, xc_q, rx_p_q, tx_p_q;
  logic [FILT_W-1:0] filt_q;
  logic [THR_W-1:0] thr_rxe_q, thr_txa_q, thr_txs_q;

  assign cmd_ready = !busy;
  assign fire      = cmd_valid && cmd_ready;

  wcs_decode u_dec (.fire(fire), .word(cmd_word), .d(d), .arg(arg));

  wcs_busy #(.CYCLES(BUSY_CYCLES)) u_busy (
    .clk(clk), .rst_n(rst_n),
    .start(d.gl_rst || d.rx_rst || d.tx_rst),
    .busy(busy));

  assign set_vec = {ev_stats, d.int_req,
                    ev_rx_early && (thr_rxe_q != THR_OFF),
                    ev_rx_done,
                    ev_tx_room && (thr_txa_q != THR_OFF),
                    ev_tx_done, ev_fail};

  wcs_irq_status #(.EV_W(EV_W)) u_irq (
    .clk(clk), .rst_n(rst_n), .clear(d.gl_rst),
    .set_vec(set_vec), .ack_en(d.int_ack), .ack_vec(arg[EV_W-1:0]),
    .mask_ld(d.mask_ld), .mask_in(arg[EV_W-1:1]),
    .ev_bits(ev_bits), .irq(irq));

  always_ff @(posedge clk) begin
    if (!rst_n || d.gl_rst) begin
      win_q     <= '0;
      rx_en_q   <= 1'b0;
      tx_en_q   <= 1'b0;
      st_q      <= 1'b0;
      xc_q      <= 1'b0;
      filt_q    <= '0;
      thr_rxe_q <= THR_OFF;
      thr_txa_q <= THR_OFF;
      thr_txs_q <= THR_OFF;
    end else begin
      if (d.win_sel) win_q <= arg[WIN_W-1:0];
      if (d.rx_on) rx_en_q <= 1'b1;
      else if (d.rx_off || d.rx_rst) rx_en_q <= 1'b0;
      if (d.tx_on) tx_en_q <= 1'b1;
      else if (d.tx_off || d.tx_rst) tx_en_q <= 1'b0;
      if (d.st_on) st_q <= 1'b1;
      else if (d.st_off) st_q <= 1'b0;
      if (d.xc_on) xc_q <= 1'b1;
      else if (d.xc_off) xc_q <= 1'b0;
      if (d.filt_ld) filt_q <= arg[FILT_W-1:0];
      if (d.thr_rxe) thr_rxe_q <= arg[THR_W-1:0];
      if (d.thr_txa) thr_txa_q <= arg[THR_W-1:0];
      if (d.thr_txs) thr_txs_q <= arg[THR_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_p_q <= 1'b0;
      tx_p_q <= 1'b0;
    end else begin
      rx_p_q <= d.gl_rst || d.rx_rst;
      tx_p_q <= d.gl_rst || d.tx_rst;
    end
  end

  assign window         = win_q;
  assign rx_enable      = rx_en_q;
  assign tx_enable      = tx_en_q;
  assign rx_reset_pulse = rx_p_q;
  assign tx_reset_pulse = tx_p_q;
  assign stats_enable   = st_q;
  assign xcvr_on        = xc_q;
  assign rx_filter      = filt_q;
  assign thr_rx_early   = thr_rxe_q;
  assign thr_tx_room    = thr_txa_q;
  assign thr_tx_start   = thr_txs_q;
  assign status_word    = {win_q, busy, 4'b0000, ev_bits};

  // R4: each reset pulse lasts a single cycle
  a_r4_rx_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    rx_reset_pulse |=> !rx_reset_pulse);
  // R2: the window moves only on a select or a global reset
  a_r2_window_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(fire && (cmd_word[15:11] == OP_WIN_SEL || cmd_word[15:11] == OP_GLOBAL_RST))
      |=> $stable(window));
  // R3: a receiver reset leaves the receiver disabled
  a_r3_rx_off_after_rst: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && cmd_word[15:11] == OP_RX_RST) |=> !rx_enable);
  // R6: a global reset returns window, events and transmitter to idle
  a_r6_global_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && cmd_word[15:11] == OP_GLOBAL_RST)
      |=> (window == 3'd0 && status_word[7:0] == 8'h00 && !tx_enable && !irq));
endmodule

// File: tb/test_wcs_cmd_status.sv
module test_wcs_cmd_status;
  localparam int BUSY = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [15:0] cmd_word = '0;
  logic ev_fail = 0, ev_tx_done = 0, ev_tx_room = 0, ev_rx_done = 0, ev_rx_early = 0, ev_stats = 0;
  logic cmd_ready, rx_enable, tx_enable, rx_reset_pulse, tx_reset_pulse, stats_enable, xcvr_on, irq;
  logic [15:0] status_word;
  logic [2:0]  window;
  logic [3:0]  rx_filter;
  logic [10:0] thr_rx_early, thr_tx_room, thr_tx_start;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  wcs_cmd_status #(.BUSY_CYCLES(BUSY)) i_wcs_cmd_status (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_word(cmd_word), .ev_fail(ev_fail), .ev_tx_done(ev_tx_done),
    .ev_tx_room(ev_tx_room), .ev_rx_done(ev_rx_done), .ev_rx_early(ev_rx_early),
    .ev_stats(ev_stats), .status_word(status_word), .window(window),
    .rx_enable(rx_enable), .tx_enable(tx_enable), .rx_reset_pulse(rx_reset_pulse),
    .tx_reset_pulse(tx_reset_pulse), .stats_enable(stats_enable), .xcvr_on(xcvr_on),
    .rx_filter(rx_filter), .thr_rx_early(thr_rx_early), .thr_tx_room(thr_tx_room),
    .thr_tx_start(thr_tx_start), .irq(irq));

  // behavioural reference model
  int m_win, m_busy, m_filt, m_mask, m_ev, m_latch, m_thr_rxe, m_thr_txa, m_thr_txs;
  bit m_rx, m_tx, m_st, m_xc, m_rxp, m_txp;

  task automatic m_init();
    m_win = 0; m_filt = 0; m_mask = 0; m_ev = 0; m_latch = 0;
    m_thr_rxe = 2047; m_thr_txa = 2047; m_thr_txs = 2047;
    m_rx = 0; m_tx = 0; m_st = 0; m_xc = 0;
  endtask

  always @(posedge clk) begin
    int op, arg, setv, ack;
    bit acc;
    if (!rst_n) begin
      m_init(); m_busy = 0; m_rxp = 0; m_txp = 0;
    end else begin
      acc = cmd_valid && (m_busy == 0);
      op  = cmd_word[15:11];
      arg = cmd_word[10:0];
      setv = 0;
      if (ev_fail)     setv |= 'h02;
      if (ev_tx_done)  setv |= 'h04;
      if (ev_tx_room && m_thr_txa != 2047) setv |= 'h08;
      if (ev_rx_done)  setv |= 'h10;
      if (ev_rx_early && m_thr_rxe != 2047) setv |= 'h20;
      if (ev_stats)    setv |= 'h80;
      ack = 0;
      m_rxp = 0; m_txp = 0;
      if (m_busy > 0) m_busy--;
      if (acc) begin
        case (op)
          'h00: begin m_init(); m_rxp = 1; m_txp = 1; m_busy = BUSY; end
          'h01: m_win = arg % 8;
          'h02: m_xc = 1;
          'h03: m_rx = 0;
          'h04: m_rx = 1;
          'h05: begin m_rx = 0; m_rxp = 1; m_busy = BUSY; end
          'h09: m_tx = 1;
          'h0A: m_tx = 0;
          'h0B: begin m_tx = 0; m_txp = 1; m_busy = BUSY; end
          'h0C: setv |= 'h40;
          'h0D: ack = arg % 256;
          'h0E: m_mask = arg & 'hFE;
          'h10: m_filt = arg % 16;
          'h11: m_thr_rxe = arg;
          'h12: m_thr_txa = arg;
          'h13: m_thr_txs = arg;
          'h15: m_st = 1;
          'h16: m_st = 0;
          'h17: m_xc = 0;
          default: ;
        endcase
      end
      if (!(acc && op == 0)) begin
        m_ev    = ((m_ev & ~ack) | setv) & 'hFE;
        m_latch = ((ack & 1) ? 0 : m_latch) | (setv != 0);
      end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2", "window", window, m_win);
      chk("R2", "status window field", status_word[15:13], m_win);
      chk("R5", "busy flag", status_word[12], m_busy != 0);
      chk("R5", "cmd_ready", cmd_ready, m_busy == 0);
      chk("R3", "rx_enable", rx_enable, m_rx);
      chk("R3", "tx_enable", tx_enable, m_tx);
      chk("R4", "rx_reset_pulse", rx_reset_pulse, m_rxp);
      chk("R4", "tx_reset_pulse", tx_reset_pulse, m_txp);
      chk("R7", "status events", status_word[7:0], m_ev | m_latch);
      chk("R1", "status reserved", status_word[11:8], 0);
      chk("R9", "irq", irq, m_latch && ((m_ev & m_mask) != 0));
      chk("R10", "rx_filter", rx_filter, m_filt);
      chk("R11", "thr rx early", thr_rx_early, m_thr_rxe);
      chk("R11", "thr tx room", thr_tx_room, m_thr_txa);
      chk("R11", "thr tx start", thr_tx_start, m_thr_txs);
      chk("R12", "stats_enable", stats_enable, m_st);
      chk("R12", "xcvr_on", xcvr_on, m_xc);
    end
  end

  task automatic set_ev(input logic [5:0] e);
    {ev_stats, ev_rx_early, ev_rx_done, ev_tx_room, ev_tx_done, ev_fail} = e;
  endtask

  task automatic do_cmd(input logic [4:0] op, input logic [10:0] arg, input logic [5:0] e);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_word = {op, arg}; set_ev(e);
    while (!cmd_ready) begin
      @(negedge clk);
      set_ev(6'd0);
    end
    @(posedge clk);
    #1;
    cmd_valid = 1'b0; set_ev(6'd0);
  endtask

  task automatic pulse_ev(input logic [5:0] e);
    @(negedge clk); set_ev(e);
    @(posedge clk); #1; set_ev(6'd0);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired, all requirements unfinished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(1);
    // R6 power-up state
    chk("R6", "thr after reset", thr_tx_start, 2047);
    chk("R3", "rx off after reset", rx_enable, 0);
    // R2 window select, argument upper bits ignored
    do_cmd(5'h01, 11'd5, 6'd0); idle(1);
    chk("R2", "window 5", window, 5);
    do_cmd(5'h01, 11'h7FA, 6'd0); idle(1);
    chk("R2", "window 2 from high arg", window, 2);
    do_cmd(5'h04, 11'h7FF, 6'd0);
    do_cmd(5'h09, 11'd0, 6'd0);
    do_cmd(5'h10, 11'h7FB, 6'd0); idle(1);
    chk("R10", "filter low nibble", rx_filter, 4'hB);
    do_cmd(5'h11, 11'd100, 6'd0);
    do_cmd(5'h13, 11'd500, 6'd0);
    // R11 tx room strobe ignored at threshold 2047
    pulse_ev(6'b000100); idle(1);
    chk("R11", "tx room ignored", status_word[3], 0);
    do_cmd(5'h12, 11'd50, 6'd0);
    pulse_ev(6'b000100); idle(1);
    chk("R7", "tx room latched", status_word[3:0], 4'b1001);
    do_cmd(5'h0E, 11'h01C, 6'd0); idle(1);
    chk("R9", "irq masked event", irq, 1);
    // R8 ack collides with tx done strobe
    do_cmd(5'h0D, 11'h00D, 6'b000010); idle(1);
    chk("R8", "ack vs event", status_word[7:0], 8'h05);
    do_cmd(5'h0D, 11'h0FF, 6'd0); idle(1);
    chk("R8", "full ack", status_word[7:0], 0);
    do_cmd(5'h0C, 11'd0, 6'b100001); idle(1);
    chk("R7", "request + fail + stats", status_word[7:0], 8'hC3);
    pulse_ev(6'b011000); idle(1);
    // R1 unknown opcodes have no effect
    do_cmd(5'h06, 11'h7FF, 6'd0);
    do_cmd(5'h14, 11'h001, 6'd0);
    do_cmd(5'h1F, 11'h7FF, 6'd0);
    do_cmd(5'h0F, 11'h7FF, 6'd0); idle(1);
    chk("R1", "unknown ops keep window", window, 2);
    do_cmd(5'h15, 11'd0, 6'd0);
    do_cmd(5'h02, 11'd0, 6'd0);
    // R4/R5 receiver reset, then a held window select
    do_cmd(5'h05, 11'd0, 6'd0);
    do_cmd(5'h01, 11'd3, 6'd0); idle(1);
    chk("R5", "held command applied after busy", window, 3);
    do_cmd(5'h0B, 11'd0, 6'd0);
    idle(BUSY + 1);
    do_cmd(5'h16, 11'd0, 6'd0);
    do_cmd(5'h17, 11'd0, 6'd0);
    do_cmd(5'h03, 11'd0, 6'd0);
    do_cmd(5'h04, 11'd0, 6'd0);
    do_cmd(5'h0A, 11'd0, 6'd0);
    do_cmd(5'h09, 11'd0, 6'd0);
    pulse_ev(6'b111111);
    // R6 global reset with a colliding event
    do_cmd(5'h00, 11'h7FF, 6'b111111); idle(1);
    chk("R6", "global reset status", status_word[7:0], 0);
    chk("R6", "global reset window", window, 0);
    idle(BUSY + 2);
    chk("R6", "filter cleared", rx_filter, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule